// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 30-bit virtual address into a physical address by walking a two-level table held in memory. A directory table is located by a root base register that software loads. The walker first reads the directory entry picked by the top bits of the virtual address. That entry either gives the base of a second-level page table or marks the region as having no table. If a table exists, the walker reads the page entry picked by the middle bits. That entry supplies the frame number, and the page offset is appended to it.

All data moves over valid/ready handshakes: translation requests come in, memory reads go out, memory responses come back, and results go out. A transfer happens on a clock edge where both valid and ready are high. A source that raises valid keeps valid and its payload unchanged until ready is seen. The walker handles one translation at a time. It issues at most one memory read at a time, and it makes no second read when the directory marks the region as empty. A result that the consumer does not take is held as it is, which stalls the walker. A memory port that is slow to accept a read or to answer also stalls the walker.

Top module: `pgwalk_top`

## Requirements
- R1: Right after reset, req_ready is 1, mem_req_valid is 0, mem_rsp_ready is 0, res_valid is 0, and the root base is 0.
- R2: The first read of a walk goes to the root base plus 4 times virtual-address bits [29:22]. The root base is the value held on the edge where the request is accepted. A root write while a walk is in progress affects only requests accepted later.
- R3: After the directory response, the second read goes to the address formed as follows: directory-entry bits [31:12] with 12 zero bits below them, plus 4 times virtual-address bits [21:12]. A walk that completes without a directory fault makes exactly two reads.
- R4: mem_req_valid stays high with an unchanged mem_req_addr until mem_req_ready is seen. mem_rsp_ready is high only while one read is outstanding. A new read is never offered while a response is awaited.
- R5: When the page entry has bit 0 set, the result is as follows: res_paddr is page-entry bits [31:12] followed by virtual-address bits [11:0], and both fault flags are 0. Bits [11:1] of an entry have no effect.
- R6: When the directory entry has bit 0 clear, the result has res_dir_fault set, res_pte_fault clear and res_paddr 0. In that case exactly one read is made, whatever the entry's upper bits hold.
- R7: When the page entry has bit 0 clear, the result has res_pte_fault set, res_dir_fault clear and res_paddr 0.
- R8: req_ready is high only when no walk is in progress. A req_valid or a changing req_vaddr during a walk has no effect on that walk.
- R9: res_valid, res_paddr and both fault flags stay unchanged until res_ready is seen. In the cycle after the result is taken, req_ready is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Load root_wdata into the root base register |
| root_wdata | input | 32 | New directory table base address |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 30 | Virtual address to translate |
| mem_req_valid | output | 1 | Memory read offered |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the 32-bit word to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_ready | output | 1 | Walker awaiting read data |
| mem_rsp_data | input | 32 | Returned table entry |
| res_valid | output | 1 | Translation result offered |
| res_ready | input | 1 | Consumer takes the result |
| res_paddr | output | 32 | Physical address, 0 on a fault |
| res_dir_fault | output | 1 | Region has no second-level table |
| res_pte_fault | output | 1 | Page entry not valid |

## Verification
A wrong walk state shows up at the ports in the same cycle, because req_ready, mem_req_valid, mem_rsp_ready and res_valid all come straight from the state and the outstanding-read flag. The bench therefore compares them against its model on every clock. A wrong address latch shows up as a bad mem_req_addr on the first cycle that read is offered. A wrong decode of an entry shows up either as an extra or missing second read, or as a wrong result within one cycle of the response. Stalls on every handshake, held results and requests offered while busy are covered, so that the hold and ignore rules are also checked.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  // bit of a table entry that marks it present / valid
  localparam int ENT_PRESENT_BIT = 0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OUTER = 2'd1,
    ST_INNER = 2'd2,
    ST_DONE  = 2'd3
  } walk_st_e;
endpackage

// File: rtl/pgw_root_reg.sv
module pgw_root_reg #(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [PA_W-1:0] wdata,
  output logic [PA_W-1:0] root
);
  always_ff @(posedge clk) begin
    if (!rst_n)  root <= '0;
    else if (we) root <= wdata;
  end
endmodule

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
  parameter int VA_W      = 30,
  parameter int DIR_IDX_W = 8,
  parameter int TBL_IDX_W = 10,
  parameter int PA_W      = 32,
  parameter int DATA_W    = 32
) (
  input  logic [PA_W-1:0]   root,
  input  logic [VA_W-1:0]   new_vaddr,
  input  logic [VA_W-1:0]   held_vaddr,
  input  logic [DATA_W-1:0] entry,
  output logic [PA_W-1:0]   dir_addr,
  output logic [PA_W-1:0]   tbl_addr,
  output logic [PA_W-1:0]   phys_addr
);
  localparam int OFF_W   = VA_W - DIR_IDX_W - TBL_IDX_W;
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int ENT_SH  = $clog2(DATA_W / 8);

  logic [DIR_IDX_W-1:0] dir_idx;
  logic [TBL_IDX_W-1:0] tbl_idx;
  logic [OFF_W-1:0]     pg_off;
  logic [FRAME_W-1:0]   frame;
  logic                 unused_bits;

  assign dir_idx = new_vaddr[VA_W-1 -: DIR_IDX_W];
  assign tbl_idx = held_vaddr[OFF_W +: TBL_IDX_W];
  assign pg_off  = held_vaddr[OFF_W-1:0];
  assign frame   = entry[OFF_W +: FRAME_W];

  assign unused_bits = ^{new_vaddr[VA_W-DIR_IDX_W-1:0],
                         held_vaddr[VA_W-1 -: DIR_IDX_W],
                         entry[OFF_W-1:0]};

  // entry addresses: table base plus index scaled by entry size
  assign dir_addr  = root + (PA_W'(dir_idx) << ENT_SH);
  assign tbl_addr  = {frame, {OFF_W{1'b0}}} + (PA_W'(tbl_idx) << ENT_SH);
  assign phys_addr = {frame, pg_off};
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
  import pgw_pkg::*;
#(
  parameter int VA_W = 30,
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  output logic [VA_W-1:0] held_vaddr,
  input  logic [PA_W-1:0] dir_addr,
  input  logic [PA_W-1:0] tbl_addr,
  input  logic [PA_W-1:0] phys_addr,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic            rsp_present,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [PA_W-1:0] res_paddr,
  output logic            res_dir_fault,
  output logic            res_pte_fault
);
  walk_st_e        st;
  logic            pending;
  logic [PA_W-1:0] addr_q;
  logic [PA_W-1:0] paddr_q;
  logic            dflt_q;
  logic            pflt_q;
  logic            walking;

  assign walking = (st == ST_OUTER) || (st == ST_INNER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      pending    <= 1'b0;
      held_vaddr <= '0;
      addr_q     <= '0;
      paddr_q    <= '0;
      dflt_q     <= 1'b0;
      pflt_q     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            held_vaddr <= req_vaddr;
            addr_q     <= dir_addr;
            pending    <= 1'b0;
            paddr_q    <= '0;
            dflt_q     <= 1'b0;
            pflt_q     <= 1'b0;
            st         <= ST_OUTER;
          end
        end
        ST_OUTER, ST_INNER: begin
          if (!pending) begin
            if (mem_req_ready) pending <= 1'b1;
          end else if (mem_rsp_valid) begin
            pending <= 1'b0;
            if (st == ST_OUTER) begin
              if (rsp_present) begin
                addr_q <= tbl_addr;
                st     <= ST_INNER;
              end else begin
                dflt_q <= 1'b1;
                st     <= ST_DONE;
              end
            end else begin
              if (rsp_present) paddr_q <= phys_addr;
              else             pflt_q  <= 1'b1;
              st <= ST_DONE;
            end
          end
        end
        ST_DONE: begin
          if (res_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = walking && !pending;
  assign mem_req_addr  = addr_q;
  assign mem_rsp_ready = walking && pending;
  assign res_valid     = (st == ST_DONE);
  assign res_paddr     = paddr_q;
  assign res_dir_fault = dflt_q;
  assign res_pte_fault = pflt_q;
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgw_pkg::*;
#(
  parameter int VA_W      = 30,
  parameter int DIR_IDX_W = 8,
  parameter int TBL_IDX_W = 10,
  parameter int PA_W      = 32,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              root_we,
  input  logic [PA_W-1:0]   root_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [PA_W-1:0]   res_paddr,
  output logic              res_dir_fault,
  output logic              res_pte_fault
);
  logic [PA_W-1:0] root;
  logic [VA_W-1:0] held_vaddr;
  logic [PA_W-1:0] dir_addr;
  logic [PA_W-1:0] tbl_addr;
  logic [PA_W-1:0] phys_addr;
  logic            rsp_present;

  assign rsp_present = mem_rsp_data[ENT_PRESENT_BIT];

  pgw_root_reg #(.PA_W(PA_W)) u_root (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (root_we),
    .wdata (root_wdata),
    .root  (root)
  );

  pgw_addr_gen #(
    .VA_W(VA_W), .DIR_IDX_W(DIR_IDX_W), .TBL_IDX_W(TBL_IDX_W),
    .PA_W(PA_W), .DATA_W(DATA_W)
  ) u_agen (
    .root       (root),
    .new_vaddr  (req_vaddr),
    .held_vaddr (held_vaddr),
    .entry      (mem_rsp_data),
    .dir_addr   (dir_addr),
    .tbl_addr   (tbl_addr),
    .phys_addr  (phys_addr)
  );

  pgw_seq #(.VA_W(VA_W), .PA_W(PA_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .held_vaddr    (held_vaddr),
    .dir_addr      (dir_addr),
    .tbl_addr      (tbl_addr),
    .phys_addr     (phys_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .rsp_present   (rsp_present),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_paddr     (res_paddr),
    .res_dir_fault (res_dir_fault),
    .res_pte_fault (res_pte_fault)
  );
endmodule

// File: rtl/pgw_chk.sv
module pgw_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_ready,
  input logic            res_valid,
  input logic            res_ready,
  input logic [PA_W-1:0] res_paddr,
  input logic            res_dir_fault,
  input logic            res_pte_fault
);
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R4
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_paddr)
      && $stable(res_dir_fault) && $stable(res_pte_fault)); // R9
  AST_BACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> req_ready); // R9
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || mem_rsp_ready || res_valid) |-> !req_ready); // R8
  AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_dir_fault && res_pte_fault)); // R6
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_dir_fault || res_pte_fault) |-> res_paddr == '0); // R7
endmodule

bind pgwalk_top pgw_chk #(.PA_W(PA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_ready (mem_rsp_ready),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_paddr     (res_paddr),
  .res_dir_fault (res_dir_fault),
  .res_pte_fault (res_pte_fault)
);

// File: tb/sim_pgwalk_top.sv
`timescale 1ns/1ps
module sim_pgwalk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_we = 1'b0;
  logic [31:0] root_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [29:0] req_vaddr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_paddr;
  logic        res_dir_fault;
  logic        res_pte_fault;

  always #4 clk = ~clk;

  pgwalk_top u0 (
    .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr),
    .res_dir_fault(res_dir_fault), .res_pte_fault(res_pte_fault)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // memory image and stall controls
  logic [31:0] mem [logic [31:0]];
  int lat_cfg = 0;
  bit stall_mode = 1'b0;

  // behavioural model: 0 idle, 1 directory read, 2 page read, 3 result
  int          m_st = 0;
  bit          m_iss = 1'b0;
  int          m_lat = 0;
  int          m_reads = 0;
  logic [31:0] m_addr = '0;
  logic [29:0] m_va = '0;
  logic [31:0] m_root = '0;
  logic [31:0] m_pa = '0;
  bit          m_fd = 1'b0;
  bit          m_fp = 1'b0;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_iss = 1'b0; m_root = '0; m_lat = 0;
    end else begin
      case (m_st)
        0: if (req_valid) begin
          m_va = req_vaddr;
          m_addr = m_root + 32'(int'(req_vaddr[29:22]) * 4);
          m_st = 1; m_iss = 1'b0; m_pa = '0; m_fd = 1'b0; m_fp = 1'b0; m_reads = 0;
        end
        1, 2: begin
          if (!m_iss) begin
            if (mem_req_ready) begin m_iss = 1'b1; m_lat = lat_cfg; m_reads++; end
          end else if (mem_rsp_valid) begin
            m_iss = 1'b0;
            if (m_st == 1) begin
              if (mem_rsp_data[0]) begin
                m_addr = (mem_rsp_data & 32'hFFFF_F000) + 32'(int'(m_va[21:12]) * 4);
                m_st = 2;
              end else begin
                m_fd = 1'b1; m_st = 3;
              end
            end else begin
              if (mem_rsp_data[0]) m_pa = (mem_rsp_data & 32'hFFFF_F000) | {20'h0, m_va[11:0]};
              else m_fp = 1'b1;
              m_st = 3;
            end
          end else if (m_lat > 0) m_lat--;
        end
        default: if (res_ready) m_st = 0;
      endcase
      if (root_we) m_root = root_wdata;
    end
  end

  // compare on every clock, then drive the memory side
  always @(negedge clk) begin
    if (cyc >= 1 && !finished) begin
      chk(req_ready == (m_st == 0), "R8 req_ready", 32'(req_ready), 32'(m_st == 0));
      chk(mem_req_valid == ((m_st == 1 || m_st == 2) && !m_iss), "R4 mem_req_valid",
          32'(mem_req_valid), 32'((m_st == 1 || m_st == 2) && !m_iss));
      if ((m_st == 1 || m_st == 2) && !m_iss)
        chk(mem_req_addr == m_addr, (m_st == 1) ? "R2 dir addr" : "R3 tbl addr",
            mem_req_addr, m_addr);
      chk(mem_rsp_ready == ((m_st == 1 || m_st == 2) && m_iss), "R4 mem_rsp_ready",
          32'(mem_rsp_ready), 32'((m_st == 1 || m_st == 2) && m_iss));
      chk(res_valid == (m_st == 3), "R9 res_valid", 32'(res_valid), 32'(m_st == 3));
      if (m_st == 3) begin
        chk(res_paddr == m_pa, "R5 res_paddr", res_paddr, m_pa);
        chk(res_dir_fault == m_fd, "R6 res_dir_fault", 32'(res_dir_fault), 32'(m_fd));
        chk(res_pte_fault == m_fp, "R7 res_pte_fault", 32'(res_pte_fault), 32'(m_fp));
      end
    end
    mem_req_ready <= stall_mode ? ((cyc % 3) == 2) : 1'b1;
    mem_rsp_valid <= (m_st == 1 || m_st == 2) && m_iss && (m_lat == 0);
    mem_rsp_data  <= ((m_st == 1 || m_st == 2) && m_iss && (m_lat == 0)) ? mem_rd(m_addr)
                                                                         : 32'h0;
  end

  task automatic set_root(input logic [31:0] v);
    @(negedge clk); root_we = 1'b1; root_wdata = v;
    @(negedge clk); root_we = 1'b0;
  endtask

  task automatic walk(input logic [29:0] va, input logic [31:0] epa, input bit efd,
                      input bit efp, input int hold, input bit poke_busy,
                      input bit poke_root, input logic [31:0] new_root, input string tag);
    int n = 0;
    @(negedge clk); req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    if (poke_busy) req_vaddr = va ^ 30'h1555_5555;
    else req_valid = 1'b0;
    if (poke_root) begin root_we = 1'b1; root_wdata = new_root; end
    while (!res_valid && n < 400) begin
      @(negedge clk); root_we = 1'b0; n++;
    end
    root_we = 1'b0;
    req_valid = 1'b0;
    chk(res_paddr == epa, {tag, " paddr"}, res_paddr, epa);
    chk(res_dir_fault == efd, {tag, " dir fault"}, 32'(res_dir_fault), 32'(efd));
    chk(res_pte_fault == efp, {tag, " pte fault"}, 32'(res_pte_fault), 32'(efp));
    chk(m_reads == (efd ? 1 : 2), efd ? "R6 read count" : "R3 read count",
        32'(m_reads), efd ? 32'd1 : 32'd2);
    repeat (hold) @(negedge clk);
    chk(res_valid == 1'b1 && res_paddr == epa, "R9 held result", res_paddr, epa);
    res_ready = 1'b1;
    @(negedge clk); res_ready = 1'b0;
    chk(req_ready == 1'b1, "R9 idle after take", 32'(req_ready), 32'd1);
  endtask

  initial begin
    // R1: directory at 0x10000, second-level tables at 0x40000 and 0x7F000
    mem[32'h0001_000C] = 32'h0004_0001;
    mem[32'h0004_0014] = 32'h1234_5001;
    mem[32'h0004_0018] = 32'h5555_5000;
    mem[32'h0001_03FC] = 32'h0007_F001;
    mem[32'h0007_FFFC] = 32'hABCD_E003;
    mem[32'h0001_0024] = 32'h0004_0000;
    mem[32'h0002_000C] = 32'h0005_0001;
    mem[32'h0005_0014] = 32'h0009_9001;

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && mem_req_valid == 1'b0 && mem_rsp_ready == 1'b0 && res_valid == 1'b0,
        "R1 reset outputs", {28'h0, req_ready, mem_req_valid, mem_rsp_ready, res_valid},
        32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: root resets to 0, so a walk now starts at address 4*dir index
    chk(mem_req_valid == 1'b0, "R1 idle after reset", 32'(mem_req_valid), 32'd0);

    set_root(32'h0001_0000);
    walk(30'h00C0_5123, 32'h1234_5123, 0, 0, 0, 0, 0, '0, "R5 basic");
    walk(30'h3FFF_FFFF, 32'hABCD_EFFF, 0, 0, 2, 0, 0, '0, "R5 max index");
    walk(30'h01C0_0000, 32'h0, 1, 0, 1, 0, 0, '0, "R6 empty dir");
    walk(30'h0240_0777, 32'h0, 1, 0, 0, 0, 0, '0, "R6 frame bits set");
    walk(30'h00C0_6456, 32'h0, 0, 1, 3, 0, 0, '0, "R7 invalid pte");

    lat_cfg = 3; stall_mode = 1'b1;
    walk(30'h00C0_5123, 32'h1234_5123, 0, 0, 4, 0, 0, '0, "R4 stalled memory");
    walk(30'h00C0_6456, 32'h0, 0, 1, 0, 1, 0, '0, "R8 busy request");
    walk(30'h00C0_5123, 32'h1234_5123, 0, 0, 0, 0, 1, 32'h0002_0000, "R2 root mid walk");
    lat_cfg = 0; stall_mode = 1'b0;
    walk(30'h00C0_5123, 32'h0009_9123, 0, 0, 0, 0, 0, '0, "R2 new root");
    walk(30'h3FFF_FFFF, 32'h0, 1, 0, 0, 1, 0, '0, "R8 busy on fault");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule